// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block reads a fixed 640x480 true-colour picture out of a linear frame buffer in memory and turns it into a pixel stream. An internal pixel/line counter walks an 800x525 raster. For every pixel inside the 640x480 visible window it issues one word read to memory. When a memory response returns, the block unpacks the 32-bit word into 8-bit red, green and blue outputs. These outputs are aligned with a data-enable strobe.

Software sets the block up through a small register port with one word per index. Index 0 holds the frame buffer base address. Only its top 11 bits steer the fetch, so the buffer must start on a 2 MiB boundary. Index 1 holds two control bits: one turns scan-out on and one selects 180-degree rotation. In rotated mode the picture is read backwards, with the last line and last column first. Each memory line is 1024 words long, and only its first 640 words are ever fetched. New settings are applied only at the start of the next frame, so a frame never mixes two settings.

Top module: `fb_scan_top`

## Requirements
- R1: A returned word drives red from bits 23:16, green from bits 15:8 and blue from bits 7:0; bits 31:24 never reach the outputs.
- R2: In normal mode the read for screen pixel (x, y) uses byte address {base[31:21], y[8:0], x[9:0], 2'b00}.
- R3: When the rotate bit is set, the read for screen pixel (x, y) uses line 479-y and column 639-x in the same address layout as R2.
- R4: While enabled, exactly one read request is made for each visible pixel, in raster order, and no request is made outside the visible window.
- R5: While disabled, no read request is made and red, green and blue stay zero during the visible window.
- R6: Writes to the base address and control registers take effect at the first pixel of the next frame; the frame in progress keeps its old settings.
- R7: Register index 0 (base) reads back all 32 bits exactly as written. Register index 1 (control) reads back bit 0 = enable and bit 1 = rotate, with bits 31:2 reading zero.
- R8: The raster is H_TOTAL x V_TOTAL pixel clocks (800x525 by default). Data enable is high only for the H_ACTIVE x V_ACTIVE visible window. The request for a position appears one cycle after that position's counter cycle. Data enable and pixel colour appear RD_LAT+1 cycles after the request, and the colour is zero whenever data enable is low.
- R9: A colour is taken only if the response-valid input is high in the cycle the response is due (RD_LAT cycles after the request); otherwise that pixel is output as zero.
- R10: While reset is asserted, the request, data enable and colour outputs are zero, and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 1 | Register index: 0 base, 1 control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i |
| mem_req_o | output | 1 | Memory read request, one per visible pixel |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_valid_i | input | 1 | Response valid, due RD_LAT cycles after request |
| mem_rdata_i | input | 32 | Response word |
| de_o | output | 1 | Data enable for the visible window |
| red_o | output | 8 | Red level |
| green_o | output | 8 | Green level |
| blue_o | output | 8 | Blue level |

## Verification
The bench drives a reduced raster through four modes. A disabled frame must show data enable with black pixels and no requests. A normal frame tells raster order apart from reversal. A rotated frame checks that both line and column are mirrored, not just one of them. A rotated-but-disabled setting shows that the enable bit alone gates fetching. The memory model returns words whose top byte is nonzero and whose colour bytes depend on every address field, so a swapped field, a lost top-byte mask or a misplaced base shows up as a colour mismatch. One response is deliberately withheld to separate valid-gated capture from blind capture. Register changes are made in mid-frame, so the settings must switch exactly at the next frame boundary.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  typedef struct packed {
    logic rot;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t unpack_px(input logic [23:0] w);
    rgb_t p;
    p.r = w[23:16];
    p.g = w[15:8];
    p.b = w[7:0];
    return p;
  endfunction

endpackage

// File: rtl/fb_scan_regs.sv
module fb_scan_regs
  import fb_scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BASE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              idx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [BASE_W-1:0] base_o,
  output ctrl_t             ctrl_o
);

  logic [ADDR_W-1:0] base_q;
  ctrl_t             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (idx_i) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      else       base_q <= wdata_i;
    end
  end

  // full word kept so software can verify ordering by readback
  assign rdata_o = idx_i ? {{(ADDR_W-2){1'b0}}, ctrl_q} : base_q;
  assign base_o  = base_q[ADDR_W-1 -: BASE_W];
  assign ctrl_o  = ctrl_q;

endmodule

// File: rtl/fb_scan_timing.sv
module fb_scan_timing #(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_TOTAL  = 800,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned V_TOTAL  = 525,
  localparam int unsigned H_CNT_W = $clog2(H_TOTAL),
  localparam int unsigned V_CNT_W = $clog2(V_TOTAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [H_CNT_W-1:0] h_o,
  output logic [V_CNT_W-1:0] v_o,
  output logic               active_o,
  output logic               frame_end_o
);

  logic [H_CNT_W-1:0] h_q;
  logic [V_CNT_W-1:0] v_q;
  logic               h_last, v_last;

  assign h_last = (h_q == H_CNT_W'(H_TOTAL - 1));
  assign v_last = (v_q == V_CNT_W'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o         = h_q;
  assign v_o         = v_q;
  assign active_o    = (h_q < H_CNT_W'(H_ACTIVE)) && (v_q < V_CNT_W'(V_ACTIVE));
  assign frame_end_o = h_last && v_last;

endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr
  import fb_scan_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned H_CNT_W  = 10,
  parameter int unsigned V_CNT_W  = 10,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned BASE_W   = 11,
  localparam int unsigned ADDR_W  = BASE_W + LINE_W + COL_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrl_t              ctrl_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [H_CNT_W-1:0] h_i,
  input  logic [V_CNT_W-1:0] v_i,
  input  logic               active_i,
  input  logic               frame_end_i,
  output logic               req_o,
  output logic               act_o,
  output logic [ADDR_W-1:0]  addr_o,
  output ctrl_t              frame_ctrl_o
);

  ctrl_t             frame_ctrl_q;
  logic [BASE_W-1:0] frame_base_q;
  logic [COL_W-1:0]  col_fwd, col;
  logic [LINE_W-1:0] line_fwd, line;
  logic              req_q, act_q;
  logic [ADDR_W-1:0] addr_q;

  // settings sampled once per frame so a frame never mixes modes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_ctrl_q <= '0;
      frame_base_q <= '0;
    end else if (frame_end_i) begin
      frame_ctrl_q <= ctrl_i;
      frame_base_q <= base_i;
    end
  end

  assign col_fwd  = COL_W'(h_i);
  assign line_fwd = LINE_W'(v_i);

  always_comb begin
    if (frame_ctrl_q.rot) begin
      col  = COL_W'(H_ACTIVE - 1) - col_fwd;
      line = LINE_W'(V_ACTIVE - 1) - line_fwd;
    end else begin
      col  = col_fwd;
      line = line_fwd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q  <= active_i && frame_ctrl_q.en;
      act_q  <= active_i;
      addr_q <= {frame_base_q, line, col, 2'b00};
    end
  end

  assign req_o        = req_q;
  assign act_o        = act_q;
  assign addr_o       = addr_q;
  assign frame_ctrl_o = frame_ctrl_q;

endmodule

// File: rtl/fb_scan_pixel.sv
module fb_scan_pixel
  import fb_scan_pkg::*;
#(
  parameter int unsigned RD_LAT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  logic        req_i,
  input  logic        valid_i,
  input  logic [31:0] rdata_i,
  output logic        de_o,
  output rgb_t        rgb_o
);

  logic [RD_LAT-1:0] act_sr, req_sr;
  logic              de_q;
  rgb_t              rgb_q;
  logic              unused_hi;

  assign unused_hi = ^rdata_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sr <= '0;
      req_sr <= '0;
    end else begin
      for (int i = RD_LAT - 1; i > 0; i--) begin
        act_sr[i] <= act_sr[i-1];
        req_sr[i] <= req_sr[i-1];
      end
      act_sr[0] <= act_i;
      req_sr[0] <= req_i;
    end
  end

  // capture only when a response is both due and valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q  <= 1'b0;
      rgb_q <= '0;
    end else begin
      de_q  <= act_sr[RD_LAT-1];
      rgb_q <= (req_sr[RD_LAT-1] && valid_i) ? unpack_px(rdata_i[23:0]) : '0;
    end
  end

  assign de_o  = de_q;
  assign rgb_o = rgb_q;

endmodule

// File: rtl/fb_scan_top.sv
module fb_scan_top
  import fb_scan_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_TOTAL  = 800,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned V_TOTAL  = 525,
  parameter int unsigned RD_LAT   = 4,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned ADDR_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_idx_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              de_o,
  output logic [7:0]        red_o,
  output logic [7:0]        green_o,
  output logic [7:0]        blue_o
);

  localparam int unsigned BASE_W  = ADDR_W - LINE_W - COL_W - 2;
  localparam int unsigned H_CNT_W = $clog2(H_TOTAL);
  localparam int unsigned V_CNT_W = $clog2(V_TOTAL);

  logic [BASE_W-1:0]  base_w;
  ctrl_t              ctrl_w;
  ctrl_t              frame_ctrl_w;
  logic [H_CNT_W-1:0] h_w;
  logic [V_CNT_W-1:0] v_w;
  logic               active_w;
  logic               frame_end_w;
  logic               act_q_w;
  rgb_t               rgb_w;

  fb_scan_regs #(
    .ADDR_W (ADDR_W),
    .BASE_W (BASE_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base_w),
    .ctrl_o  (ctrl_w)
  );

  fb_scan_timing #(
    .H_ACTIVE (H_ACTIVE),
    .H_TOTAL  (H_TOTAL),
    .V_ACTIVE (V_ACTIVE),
    .V_TOTAL  (V_TOTAL)
  ) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_o         (h_w),
    .v_o         (v_w),
    .active_o    (active_w),
    .frame_end_o (frame_end_w)
  );

  fb_scan_addr #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE),
    .H_CNT_W  (H_CNT_W),
    .V_CNT_W  (V_CNT_W),
    .COL_W    (COL_W),
    .LINE_W   (LINE_W),
    .BASE_W   (BASE_W)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl_w),
    .base_i       (base_w),
    .h_i          (h_w),
    .v_i          (v_w),
    .active_i     (active_w),
    .frame_end_i  (frame_end_w),
    .req_o        (mem_req_o),
    .act_o        (act_q_w),
    .addr_o       (mem_addr_o),
    .frame_ctrl_o (frame_ctrl_w)
  );

  fb_scan_pixel #(
    .RD_LAT (RD_LAT)
  ) u_pixel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act_q_w),
    .req_i   (mem_req_o),
    .valid_i (mem_valid_i),
    .rdata_i (mem_rdata_i),
    .de_o    (de_o),
    .rgb_o   (rgb_w)
  );

  assign red_o   = rgb_w.r;
  assign green_o = rgb_w.g;
  assign blue_o  = rgb_w.b;

endmodule

// File: rtl/fb_scan_chk.sv
module fb_scan_chk #(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned ADDR_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_idx_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic [ADDR_W-1:0] reg_rdata_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              de_o,
  input logic [7:0]        red_o,
  input logic [7:0]        green_o,
  input logic [7:0]        blue_o,
  input logic              active_w,
  input logic              frame_end_w,
  input logic [1:0]        frame_ctrl_w
);

  logic [COL_W-1:0]  col_f;
  logic [LINE_W-1:0] line_f;

  assign col_f  = mem_addr_o[COL_W+1:2];
  assign line_f = mem_addr_o[COL_W+LINE_W+1:COL_W+2];

  assert_req_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(active_w));

  assert_addr_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && 32'(col_f) < H_ACTIVE && 32'(line_f) < V_ACTIVE));

  assert_no_fetch_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ctrl_w[0] |=> !mem_req_o);

  assert_black_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (red_o == 8'h0 && green_o == 8'h0 && blue_o == 8'h0));

  assert_frame_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_w |=> $stable(frame_ctrl_w));

  assert_base_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_idx_i) |=> (reg_idx_i || reg_rdata_o == $past(reg_wdata_i)));

  assert_ctrl_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i) |=>
      (!reg_idx_i || reg_rdata_o == {{(ADDR_W-2){1'b0}}, $past(reg_wdata_i[1:0])}));

endmodule

bind fb_scan_top fb_scan_chk #(
  .H_ACTIVE (H_ACTIVE),
  .V_ACTIVE (V_ACTIVE),
  .COL_W    (COL_W),
  .LINE_W   (LINE_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_idx_i    (reg_idx_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .de_o         (de_o),
  .red_o        (red_o),
  .green_o      (green_o),
  .blue_o       (blue_o),
  .active_w     (active_w),
  .frame_end_w  (frame_end_w),
  .frame_ctrl_w (frame_ctrl_w)
);

// File: tb/fb_scan_top_tb.sv
module fb_scan_top_tb;

  localparam int HA  = 8;
  localparam int HT  = 12;
  localparam int VA  = 4;
  localparam int VT  = 6;
  localparam int LAT = 3;
  localparam int R   = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_idx = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic        de;
  logic [7:0]  red, green, blue;

  always #4 clk = ~clk;

  fb_scan_top #(
    .H_ACTIVE (HA), .H_TOTAL (HT), .V_ACTIVE (VA), .V_TOTAL (VT), .RD_LAT (LAT)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_we_i (reg_we), .reg_idx_i (reg_idx), .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr), .mem_valid_i (mem_valid), .mem_rdata_i (mem_rdata),
    .de_o (de), .red_o (red), .green_o (green), .blue_o (blue)
  );

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 0;

  logic [31:0] sh_base = '0, fr_base = '0;
  logic [1:0]  sh_ctrl = '0, fr_ctrl = '0;
  bit          drop_en = 0;
  logic [31:0] drop_addr = '0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] memword(input logic [31:0] a);
    return {8'hC3, a[13:6] ^ 8'h5A, a[21:14] ^ a[9:2], a[9:2] + 8'h11};
  endfunction

  function automatic logic [31:0] pix_addr(input logic [31:0] b, input int x, input int y, input bit rot);
    int c, l;
    c = rot ? HA - 1 - x : x;
    l = rot ? VA - 1 - y : y;
    return (b & 32'hFFE0_0000) | (32'(l) << 12) | (32'(c) << 2);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: response valid RD_LAT cycles after the request cycle
  logic        mv [LAT];
  logic [31:0] ma [LAT];
  logic        md [LAT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin mv[i] <= 1'b0; ma[i] <= '0; md[i] <= 1'b0; end
    end else begin
      for (int i = LAT - 1; i > 0; i--) begin mv[i] <= mv[i-1]; ma[i] <= ma[i-1]; md[i] <= md[i-1]; end
      mv[0] <= mem_req;
      ma[0] <= mem_addr;
      md[0] <= drop_en && (mem_addr == drop_addr);
    end
  end

  assign mem_valid = mv[LAT-1] && !md[LAT-1];
  assign mem_rdata = memword(ma[LAT-1]);

  always @(posedge clk) if (rst_n) n <= n + 1;

  // driver side pushes expected pixels, monitor side pops them on data enable
  always @(negedge clk) begin
    int p, x, y;
    bit act, dr;
    logic [31:0] ea, w;
    if (rst_n && !done && n > 0) begin
      p = (n - 1) % R;
      if (p == 0) begin fr_ctrl = sh_ctrl; fr_base = sh_base; end
      x = p % HT; y = p / HT;
      act = (x < HA) && (y < VA);
      if (act && fr_ctrl[0]) begin
        check(mem_req == 1'b1, "R4 R6 request expected", 32'(mem_req), 32'd1);
        ea = pix_addr(fr_base, x, y, fr_ctrl[1]);
        if (mem_req) check(mem_addr == ea, fr_ctrl[1] ? "R3 rotated address" : "R2 address", mem_addr, ea);
        dr = drop_en && (ea == drop_addr);
        w  = memword(ea);
        exp_q.push_back(dr ? 24'h0 : w[23:0]);
        tag_q.push_back(dr ? "R9 withheld response" : "R1 unpacked colour");
      end else begin
        check(mem_req == 1'b0, act ? "R5 R6 no request while off" : "R4 no request outside window",
              32'(mem_req), 32'd0);
        if (act) begin exp_q.push_back(24'h0); tag_q.push_back("R5 black while off"); end
      end
      if (n >= LAT + 2) begin
        p = (n - LAT - 2) % R;
        x = p % HT; y = p / HT;
        act = (x < HA) && (y < VA);
        check(de == act, "R8 data enable timing", 32'(de), 32'(act));
        if (de) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected pixel", 32'({red, green, blue}), 32'd0);
          end else begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({red, green, blue} == e, t, 32'({red, green, blue}), 32'(e));
          end
        end else begin
          check({red, green, blue} == 24'h0, "R8 black outside window", 32'({red, green, blue}), 32'd0);
        end
      end
    end
  end

  task automatic wait_slot();
    do @(negedge clk); while ((n % R) != 60);
  endtask

  task automatic reg_write(input logic idx, input logic [31:0] d);
    wait_slot();
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (idx) sh_ctrl = d[1:0];
    else     sh_base = d;
  endtask

  task automatic reg_read(input logic idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_idx = idx;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic run_frames(input int k);
    repeat (k * R) @(negedge clk);
  endtask

  initial begin
    #20;
    check(mem_req == 1'b0, "R10 reset request", 32'(mem_req), 32'd0);
    check(de == 1'b0, "R10 reset data enable", 32'(de), 32'd0);
    check({red, green, blue} == 24'h0, "R10 reset colour", 32'({red, green, blue}), 32'd0);
    reg_idx = 1'b0; #1;
    check(reg_rdata == 32'h0, "R10 reset base", reg_rdata, 32'h0);
    reg_idx = 1'b1; #1;
    check(reg_rdata == 32'h0, "R10 reset control", reg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    reg_write(1'b0, 32'h1234_5678);
    reg_read(1'b0, 32'h1234_5678, "R7 base readback");
    reg_write(1'b1, 32'hFFFF_FFF1);
    reg_read(1'b1, 32'h0000_0001, "R7 control readback");
    run_frames(2);

    reg_write(1'b1, 32'h0000_0003);
    drop_addr = pix_addr(sh_base, 2, 1, 1'b1);
    drop_en = 1;
    run_frames(2);
    wait_slot();
    drop_en = 0;

    reg_write(1'b1, 32'h0000_0000);
    run_frames(1);
    reg_write(1'b1, 32'h0000_0002);
    reg_read(1'b1, 32'h0000_0002, "R7 rotate-only readback");
    run_frames(1);

    reg_write(1'b0, 32'hFFE0_0ABC);
    reg_read(1'b0, 32'hFFE0_0ABC, "R7 base readback high");
    reg_write(1'b1, 32'h0000_0001);
    run_frames(1);
    repeat (LAT + 4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule